// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets a host read and write a bank of 32 eight-bit configuration registers. The host frames each transaction by pulling chip select low. The first byte is an instruction that holds an access direction, a data byte count and the start address. One to four data bytes follow. After each data byte the register address steps down by one.

Two wirings are supported. In 3-wire mode a single bidirectional pin carries both write data and read data. In 4-wire mode that pin is input only and a second pin returns read data. A configuration bit inside the register bank selects the wiring and comes out of reset in 3-wire mode. The whole bank is presented in parallel to the logic it configures.

Top module: `spi_cfg_port`

## Requirements
- R1: While `rst_n` is low, every register holds 0x00, `sdo` is 0 and `sdio` is not driven. Reset is asynchronous and also ends any transaction in progress.
- R2: The instruction is 8 bits, sampled on rising `sclk` edges, most significant bit first. Bit 7 is the direction (0 = write, 1 = read), bits 6:5 are the byte count code and bits 4:0 are the start address.
- R3: A count code of c transfers exactly c+1 data bytes. Clock edges after the last data byte move no data, write nothing and drive no read bits.
- R4: Each data byte after the first uses the next lower register address, and the address after 0 is 31.
- R5: Write data bytes are shifted in most significant bit first. The register is updated at the rising edge that samples the byte's last bit.
- R6: Read data is driven starting at the falling `sclk` edge after the last instruction bit, one bit per falling edge, most significant bit first, so that the host samples each bit on the next rising edge.
- R7: In 3-wire mode, `sdio` is driven only during the data phase of a read and only while `cs_n` is low. `sdo` stays 0.
- R8: Bit 0 of register 0 selects the wiring (0 = 3-wire, 1 = 4-wire). In 4-wire mode, read data appears on `sdo`, `sdio` is never driven, and `sdo` is 0 outside a read data phase.
- R9: If `cs_n` rises before a byte is complete, the partial byte is discarded and no register changes. The next transaction starts cleanly with a new instruction.
- R10: A register changes only when a complete write data byte addressed to it is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; samples on rising edge, drives on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transaction frame |
| sdio | inout | 1 | Serial data in; also read data out in 3-wire mode |
| sdo | output | 1 | Read data out in 4-wire mode, 0 otherwise |
| cfg_regs | output | 256 | All 32 registers; register a sits at bits [8a+7:8a] |

## Verification
Three situations are hard to reach from the ports. The first is a burst that crosses address 0. The second is a chip select that rises part way through a byte. The third is a wiring change made from inside the register bank while the port is in use. The stimulus covers the wrap by starting bursts near address 0. It covers the early chip-select rise by ending frames after a chosen number of instruction or data bits, then reading back the target register. It covers the wiring change by writing the mode bit in mid-run and then repeating the read sweep over the second pin, with extra clock bits after each burst to show that the pins fall quiet.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
   typedef enum logic [1:0] {
      PH_INSTR = 2'd0,
      PH_DATA  = 2'd1,
      PH_DONE  = 2'd2
   } phase_t;

   typedef enum int {
      WIRE_RUNTIME = 0,
      WIRE_FIX3    = 1,
      WIRE_FIX4    = 2
   } wiring_t;
endpackage

// File: rtl/spi_cfg_engine.sv
module spi_cfg_engine
   import spi_cfg_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int CNT_W  = 2,
   parameter int DATA_W = 8
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              din,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_active,
   output logic              tx_en,
   output logic              tx_bit
);
   localparam int INSTR_W = 1 + CNT_W + ADDR_W;
   localparam int WORD_W  = (INSTR_W > DATA_W) ? INSTR_W : DATA_W;
   localparam int BC_W    = $clog2(WORD_W);

   if (WORD_W < 3) begin : g_chk_word
      $error("spi_cfg_engine: word width too small");
   end
   if (CNT_W < 1 || ADDR_W < 1) begin : g_chk_fields
      $error("spi_cfg_engine: count and address fields need at least one bit");
   end

   phase_t            phase;
   logic [BC_W-1:0]   bitc;
   logic [WORD_W-2:0] sh;
   logic              rw;
   logic [CNT_W-1:0]  left;
   logic              sess_rst_n;
   logic [WORD_W-1:0] word;
   logic              last_bit;
   logic [BC_W-1:0]   tx_idx;

   assign sess_rst_n = rst_n & ~cs_n;
   assign word       = {sh, din};
   assign last_bit   = (phase == PH_INSTR) ? (bitc == BC_W'(INSTR_W - 1))
                                           : (bitc == BC_W'(DATA_W - 1));
   assign wr_en      = (phase == PH_DATA) && !rw && last_bit;
   assign wr_data    = word[DATA_W-1:0];
   assign rd_active  = (phase == PH_DATA) && rw;
   assign tx_idx     = BC_W'(DATA_W - 1) - bitc;

   // Rising edge: shift, count bits, decode instruction, step address.
   always_ff @(posedge sclk or negedge sess_rst_n) begin
      if (!sess_rst_n) begin
         phase <= PH_INSTR;
         bitc  <= '0;
         sh    <= '0;
         rw    <= 1'b0;
         left  <= '0;
         addr  <= '0;
      end else if (phase != PH_DONE) begin
         sh   <= {sh[WORD_W-3:0], din};
         bitc <= last_bit ? '0 : bitc + 1'b1;
         if (last_bit) begin
            if (phase == PH_INSTR) begin
               rw    <= word[INSTR_W-1];
               left  <= word[ADDR_W +: CNT_W];
               addr  <= word[ADDR_W-1:0];
               phase <= PH_DATA;
            end else begin
               addr <= addr - 1'b1;
               if (left == '0) phase <= PH_DONE;
               else            left  <= left - 1'b1;
            end
         end
      end
   end

   // Falling edge: present the next read bit.
   always_ff @(negedge sclk or negedge sess_rst_n) begin
      if (!sess_rst_n) begin
         tx_en  <= 1'b0;
         tx_bit <= 1'b0;
      end else begin
         tx_en  <= rd_active;
         tx_bit <= rd_active ? rd_data[tx_idx] : 1'b0;
      end
   end

   assert_addr_step_R4: assert property (@(posedge sclk) disable iff (!sess_rst_n)
      (phase == PH_DATA && last_bit) |=> (addr == ADDR_W'($past(addr) - 1'b1)));

   assert_instr_done_R3: assert property (@(posedge sclk) disable iff (!sess_rst_n)
      (phase == PH_INSTR && last_bit) |=> (phase == PH_DATA && bitc == '0));

   assert_done_quiet_R3: assert property (@(posedge sclk) disable iff (!sess_rst_n)
      (phase == PH_DONE) |=> (phase == PH_DONE && !wr_en));

   assert_tx_read_R6: assert property (@(posedge sclk) disable iff (!sess_rst_n)
      tx_en |-> rw);
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank #(
   parameter int                ADDR_W  = 5,
   parameter int                DATA_W  = 8,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic                             sclk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_W-1:0]                wr_data,
   output logic [DATA_W-1:0]                rd_data,
   output logic [(1<<ADDR_W)*DATA_W-1:0]    flat
);
   localparam int NREG = 1 << ADDR_W;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge sclk or negedge rst_n) begin
         if (!rst_n)                               q <= RST_VAL;
         else if (wr_en && addr == ADDR_W'(g))     q <= wr_data;
      end
      assign flat[g*DATA_W +: DATA_W] = q;
   end

   assign rd_data = flat[addr*DATA_W +: DATA_W];

   assert_hold_R10: assert property (@(posedge sclk) disable iff (!rst_n)
      !wr_en |=> $stable(flat));
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
   import spi_cfg_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int CNT_W    = 2,
   parameter int DATA_W   = 8,
   parameter int MODE_REG = 0,
   parameter int MODE_BIT = 0,
   parameter int WIRING   = WIRE_RUNTIME
) (
   input  logic                            sclk,
   input  logic                            rst_n,
   input  logic                            cs_n,
   inout  wire                             sdio,
   output logic                            sdo,
   output logic [(1<<ADDR_W)*DATA_W-1:0]   cfg_regs
);
   localparam int NREG = 1 << ADDR_W;

   if (MODE_REG >= NREG || MODE_BIT >= DATA_W) begin : g_chk_mode
      $error("spi_cfg_port: mode bit outside the register bank");
   end
   if (WIRING > WIRE_FIX4) begin : g_chk_wiring
      $error("spi_cfg_port: unknown wiring option");
   end

   logic [ADDR_W-1:0] addr;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;
   logic              rd_active;
   logic              tx_en;
   logic              tx_bit;
   logic              four_wire;
   logic              sdio_oe;

   spi_cfg_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_engine (
      .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(sdio), .rd_data(rd_data),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_active(rd_active),
      .tx_en(tx_en), .tx_bit(tx_bit)
   );

   spi_cfg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .flat(cfg_regs)
   );

   if (WIRING == WIRE_FIX3) begin : g_wire3
      assign four_wire = 1'b0;
   end else if (WIRING == WIRE_FIX4) begin : g_wire4
      assign four_wire = 1'b1;
   end else begin : g_wire_rt
      assign four_wire = cfg_regs[MODE_REG*DATA_W + MODE_BIT];
   end

   assign sdio_oe = tx_en & ~cs_n & ~four_wire;
   assign sdio    = sdio_oe ? tx_bit : 1'bz;
   assign sdo     = tx_en & ~cs_n & four_wire & tx_bit;

   assert_oe_read_R7: assert property (@(posedge sclk) disable iff (!rst_n)
      sdio_oe |-> rd_active);

   assert_sdo_read_R8: assert property (@(posedge sclk) disable iff (!rst_n)
      sdo |-> rd_active);
endmodule

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
   logic         sclk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         drv_oe = 1'b0;
   logic         drv_bit = 1'b0;
   wire          sdio;
   logic         sdo;
   logic [255:0] cfg_regs;

   logic [7:0]   model [32];
   logic         mode4 = 1'b0;
   int           n_run = 0;
   int           n_fail = 0;

   assign sdio = drv_oe ? drv_bit : 1'bz;

   always #2 sclk = ~sclk;

   spi_cfg_port u0 (
      .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdio(sdio), .sdo(sdo), .cfg_regs(cfg_regs)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge sclk);
      cs_n = 1'b0; drv_oe = 1'b1; drv_bit = b;
      @(posedge sclk);
   endtask

   task automatic finish_frame();
      @(negedge sclk);
      cs_n = 1'b1; drv_oe = 1'b0;
      @(negedge sclk);
   endtask

   task automatic send_instr(input logic rw, input int n, input int a);
      logic [7:0] ins;
      ins = {rw, 2'(n - 1), 5'(a)};
      for (int i = 7; i >= 0; i--) send_bit(ins[i]);
   endtask

   // n data bytes from data[31:24] downwards, then extra junk bits.
   task automatic write_burst(input int a, input int n, input logic [31:0] data, input int extra);
      send_instr(1'b0, n, a);
      for (int k = 0; k < n; k++) begin
         for (int i = 7; i >= 0; i--) send_bit(data[31 - 8*k - (7 - i)]);
         model[(a - k) & 31] = data[31 - 8*k -: 8];
      end
      for (int i = 0; i < extra; i++) send_bit(i[0]);
      finish_frame();
      mode4 = model[0][0];
   endtask

   task automatic read_burst(input int a, input int n, input int extra, input string req);
      logic [7:0] got;
      logic       quiet;
      send_instr(1'b1, n, a);
      for (int k = 0; k < n; k++) begin
         quiet = 1'b1;
         for (int i = 7; i >= 0; i--) begin
            @(negedge sclk);
            drv_oe = 1'b0;
            #1;
            got[i] = mode4 ? sdo : sdio;
            if (mode4 && sdio === 1'b1) quiet = 1'b0;
            if (!mode4 && sdo !== 1'b0) quiet = 1'b0;
            @(posedge sclk);
         end
         chk(got == model[(a - k) & 31], req, got, model[(a - k) & 31]);
         chk(quiet, mode4 ? "R8 sdio undriven in 4-wire" : "R7 sdo idle in 3-wire", quiet, 1);
      end
      if (extra > 0) begin
         quiet = 1'b1;
         for (int i = 0; i < extra; i++) begin
            @(negedge sclk); #1;
            if (sdo !== 1'b0) quiet = 1'b0;
            if (mode4 && sdio === 1'b1) quiet = 1'b0;
            @(posedge sclk);
         end
         chk(quiet, "R3 no read bits after count", quiet, 1);
      end
      finish_frame();
   endtask

   task automatic check_bank(input string req);
      logic ok;
      ok = 1'b1;
      for (int a = 0; a < 32; a++) if (cfg_regs[a*8 +: 8] !== model[a]) ok = 1'b0;
      chk(ok, req, ok, 1);
   endtask

   initial begin
      for (int a = 0; a < 32; a++) model[a] = 8'h00;
      repeat (3) @(negedge sclk);
      // R1: reset state
      check_bank("R1 registers cleared in reset");
      chk(sdo === 1'b0, "R1 sdo low in reset", sdo, 0);
      chk(sdio !== 1'b1, "R1 sdio released in reset", sdio, 0);
      rst_n = 1'b1;
      @(negedge sclk);

      // R2/R5: single byte, bit order checked on the parallel outputs
      write_burst(21, 1, 32'hA500_0000, 0);
      chk(cfg_regs[21*8 +: 8] == 8'hA5, "R2 R5 instruction and data bit order", cfg_regs[21*8 +: 8], 8'hA5);

      // R1: reset in the middle of a write frame
      send_instr(1'b0, 1, 10);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      @(negedge sclk); rst_n = 1'b0;
      for (int a = 0; a < 32; a++) model[a] = 8'h00;
      @(negedge sclk); cs_n = 1'b1; drv_oe = 1'b0;
      check_bank("R1 asynchronous reset mid-frame");
      @(negedge sclk); rst_n = 1'b1;
      @(negedge sclk);

      // Fill: burst crossing 0 (R4 wrap), then bursts of 4 down from 31
      write_burst(1, 4, 32'h1234_5678 & 32'hFFFE_FFFF, 0);
      check_bank("R4 write burst wraps from 0 to 31");
      for (int s = 31; s >= 3; s -= 4) begin
         logic [31:0] d;
         d = {8'(s*37 + 91), 8'(s*29 + 3), 8'(s*53 + 17), 8'(s*11 + 200)};
         if (s == 3) d[7:0] = d[7:0] & 8'hFE;
         write_burst(s, 4, d, 0);
      end
      write_burst(5, 1, 32'hFF00_0000, 0);
      check_bank("R5 bank after burst fill");

      // R2/R3/R4/R6: every start address with every count, 3-wire
      for (int a = 0; a < 32; a++)
         for (int n = 1; n <= 4; n++)
            read_burst(a, n, 0, "R6 3-wire read data");

      // R7: pin released after a read of 0xFF
      read_burst(5, 1, 0, "R6 read of all-ones register");
      #1;
      chk(sdio !== 1'b1, "R7 sdio released after frame", sdio, 0);

      // R9: frame cut part way through a data byte
      send_instr(1'b0, 1, 12);
      for (int i = 0; i < 5; i++) send_bit(i[0]);
      finish_frame();
      check_bank("R9 partial data byte discarded");
      // R9: frame cut inside the instruction, then a clean frame
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      finish_frame();
      write_burst(12, 1, 32'h3C00_0000, 0);
      check_bank("R9 clean frame after cut instruction");

      // R10/R3: junk bits after the counted bytes write nothing
      write_burst(9, 2, 32'h6699_0000, 16);
      check_bank("R10 no write beyond byte count");

      // R8: switch to 4-wire, sweep with trailing bits
      write_burst(0, 1, {7'h2A, 1'b1, 24'h0}, 0);
      chk(mode4 == 1'b1, "R8 mode bit set", mode4, 1);
      for (int a = 0; a < 32; a++)
         read_burst(a, (a % 4) + 1, 8, "R8 4-wire read data");

      // Back to 3-wire and confirm the data pin returns
      write_burst(0, 1, 32'h4000_0000, 0);
      read_burst(2, 3, 0, "R8 return to 3-wire read");
      check_bank("R10 final bank contents");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(150000 * 4);
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule